// File: doc/BRIEF.md
# SRAM Access Front End with Write Lockout

This block is the control front end of a static RAM that sits beside a nonvolatile shadow array. It watches active-low chip enable, output enable and write enable, plus an active-low store-busy line, and sorts every clock cycle into one of four kinds: deselected, selected but idle, read or write. A read loads the addressed word into an output register and raises the output-drive enable. A write stores the data word into an internal array. The bus timing of an asynchronous part is reduced here to whole-cycle behaviour: inputs are sampled on the rising clock edge and every output is registered.

Writes pass through a guard. The guard rejects them while the supply is below its switching level and while a nonvolatile transfer runs. It also rejects them after a store or recall finishes, or after reset, when chip enable and write enable are still both low at that moment. That stretch lasts until the bus leaves write-mode conditions and enters them again through a new falling edge. Each accepted write produces a single pulse on `write_event`, which a neighbouring store sequencer uses to mark the array as modified. The array depth is set by `ADDR_W`. The full-size configuration uses 13 address bits (8192 words), while the default is smaller.

Top module: `sram_guard_front`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `dout_en` and `write_event` are 0.
- R2: A cycle with `ce_n`=0, `oe_n`=0, `we_n`=1, `busy_n`=1 and `nv_active`=0 is a read. After that clock edge `dout_en` is 1 and `rdata` holds the word at `addr`. Consecutive reads follow each address change.
- R3: A cycle with `ce_n`=0, `we_n`=0 and `busy_n`=1 is a write. It stores `wdata` at `addr` on that edge when `supply_ok`=1, `nv_active`=0, `nv_done`=0 and the lockout is clear.
- R4: A cycle with `ce_n`=1 deselects the block. After that edge `dout_en` is 0 and nothing is stored.
- R5: Whenever `we_n`=0, the next `dout_en` is 0, whatever `oe_n` is. This also holds when `we_n` was already low before `ce_n` fell.
- R6: `write_event` is high for exactly one cycle, starting the cycle after the first accepted cycle of a write. A write held for several cycles gives one pulse.
- R7: With `supply_ok`=0 no write is accepted and no `write_event` appears.
- R8: With `nv_active`=1 or `busy_n`=0 there is no read (next `dout_en`=0) and no accepted write.
- R9: A cycle with `nv_done`=1 while `ce_n`=0 and `we_n`=0 arms the lockout. Writes stay rejected until `ce_n` or `we_n` is sampled high and then low again. `nv_done` with the bus not in write mode arms nothing.
- R10: If `ce_n` and `we_n` are both low when reset is released, writes stay rejected until a new falling edge of either one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| busy_n | input | 1 | Store busy, active low; blocks reads and writes |
| supply_ok | input | 1 | 1 when the supply is above the switching level |
| nv_active | input | 1 | 1 while a nonvolatile store or recall runs |
| nv_done | input | 1 | One-cycle pulse when a store or recall finishes |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| dout_en | output | 1 | Output drive enable; 0 means high impedance |
| write_event | output | 1 | One pulse per accepted write |

## Verification
A completion pulse on `nv_done` can land in the same cycle as a write request. In that case the cycle's write must be dropped and the lockout armed at once. The bench provokes this by holding `ce_n` and `we_n` low across the `nv_done` cycle with fresh data on each cycle. It then judges the result by the absence of `write_event`, by the earlier array contents returned on a later read, and by the first accepted pulse appearing only after `we_n` has been taken high and low again. In the same way, a reset released under held write-mode conditions is paired with a write attempt in the first cycle after reset.

// File: rtl/sgf_pkg.sv
package sgf_pkg;

   typedef enum logic [1:0] {
      CYC_STANDBY = 2'd0,
      CYC_IDLE    = 2'd1,
      CYC_READ    = 2'd2,
      CYC_WRITE   = 2'd3
   } cyc_kind_t;

   localparam int unsigned SGF_MAX_ADDR_W = 16;

endpackage

// File: rtl/sgf_cycle_decode.sv
module sgf_cycle_decode
   import sgf_pkg::*;
(
   input  logic      ce_n,
   input  logic      oe_n,
   input  logic      we_n,
   input  logic      busy_n,
   output cyc_kind_t kind,
   output logic      both_low
);

   always_comb begin
      both_low = !ce_n && !we_n;
      if (ce_n)
         kind = CYC_STANDBY;
      else if (!we_n && busy_n)
         kind = CYC_WRITE;
      else if (!oe_n && we_n && busy_n)
         kind = CYC_READ;
      else
         kind = CYC_IDLE;
   end

endmodule

// File: rtl/sgf_write_lock.sv
module sgf_write_lock (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic both_low,
   output logic locked
);

   logic locked_q;

   // Armed by reset or by a finished transfer under write mode; released
   // once the bus is seen outside write mode (re-entry needs a new edge).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         locked_q <= 1'b1;
      else if (arm)
         locked_q <= 1'b1;
      else if (!both_low)
         locked_q <= 1'b0;
   end

   assign locked = locked_q;

endmodule

// File: rtl/sgf_word_store.sv
module sgf_word_store
   import sgf_pkg::*;
#(
   parameter int unsigned ADDR_W     = 10,
   parameter int unsigned DATA_W     = 8,
   parameter bit          HOLD_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > SGF_MAX_ADDR_W) begin : g_bad_addr_w
      $error("sgf_word_store: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("sgf_word_store: DATA_W must be positive");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk) begin
      if (wr_en)
         mem[addr] <= wdata;
   end

   if (HOLD_RDATA) begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rdata_q <= '0;
         else if (rd_en)
            rdata_q <= mem[addr];
      end
   end else begin : g_zero
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rdata_q <= '0;
         else
            rdata_q <= rd_en ? mem[addr] : '0;
      end
   end

   assign rdata = rdata_q;

endmodule

// File: rtl/sram_guard_front.sv
module sram_guard_front
   import sgf_pkg::*;
#(
   parameter int unsigned ADDR_W     = 10,
   parameter int unsigned DATA_W     = 8,
   parameter bit          HOLD_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              busy_n,
   input  logic              supply_ok,
   input  logic              nv_active,
   input  logic              nv_done,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              dout_en,
   output logic              write_event
);

   cyc_kind_t kind;
   logic      both_low;
   logic      locked;
   logic      rd_go;
   logic      wr_go;
   logic      arm_lock;
   logic      wr_go_q;
   logic      dout_en_q;
   logic      event_q;

   sgf_cycle_decode u_decode (
      .ce_n     (ce_n),
      .oe_n     (oe_n),
      .we_n     (we_n),
      .busy_n   (busy_n),
      .kind     (kind),
      .both_low (both_low)
   );

   assign arm_lock = nv_done && both_low;

   sgf_write_lock u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (arm_lock),
      .both_low (both_low),
      .locked   (locked)
   );

   always_comb begin
      rd_go = (kind == CYC_READ) && !nv_active;
      wr_go = (kind == CYC_WRITE) && supply_ok && !nv_active
              && !nv_done && !locked;
   end

   sgf_word_store #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .HOLD_RDATA (HOLD_RDATA)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_go),
      .rd_en (rd_go),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_en_q <= 1'b0;
         wr_go_q   <= 1'b0;
         event_q   <= 1'b0;
      end else begin
         dout_en_q <= rd_go;
         wr_go_q   <= wr_go;
         event_q   <= wr_go && !wr_go_q;
      end
   end

   assign dout_en     = dout_en_q;
   assign write_event = event_q;

endmodule

// File: rtl/sram_guard_front_chk.sv
module sram_guard_front_chk (
   input logic clk,
   input logic rst_n,
   input logic ce_n,
   input logic oe_n,
   input logic we_n,
   input logic busy_n,
   input logic supply_ok,
   input logic nv_active,
   input logic nv_done,
   input logic dout_en,
   input logic write_event
);

   assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && we_n && busy_n && !nv_active) |=> dout_en);

   assert_deselect_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> !dout_en);

   assert_we_low_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |=> !dout_en);

   assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      write_event |=> !write_event);

   assert_low_supply_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> !write_event);

   assert_nv_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_active || !busy_n) |=> (!dout_en && !write_event));

   assert_done_blocks_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_done && !ce_n && !we_n) |=> !write_event);

endmodule

bind sram_guard_front sram_guard_front_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ce_n        (ce_n),
   .oe_n        (oe_n),
   .we_n        (we_n),
   .busy_n      (busy_n),
   .supply_ok   (supply_ok),
   .nv_active   (nv_active),
   .nv_done     (nv_done),
   .dout_en     (dout_en),
   .write_event (write_event)
);

// File: tb/sram_guard_front_tb_top.sv
module sram_guard_front_tb_top;

   localparam int unsigned AW = 10;
   localparam int unsigned DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy_n = 1'b1;
   logic          supply_ok = 1'b1, nv_active = 1'b0, nv_done = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          dout_en, write_event;

   always #10 clk = ~clk;

   sram_guard_front #(.ADDR_W(AW), .DATA_W(DW), .HOLD_RDATA(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .busy_n(busy_n), .supply_ok(supply_ok), .nv_active(nv_active),
      .nv_done(nv_done), .addr(addr), .wdata(wdata), .rdata(rdata),
      .dout_en(dout_en), .write_event(write_event)
   );

   typedef struct {
      logic          en;
      logic          ev;
      logic          chk_d;
      logic [DW-1:0] d;
      string         req;
   } exp_t;

   exp_t          sb[$];
   int            checks = 0;
   int            fails  = 0;
   logic [DW-1:0] model [1 << AW];

   // Driver: apply one cycle of inputs, push what the outputs must show after the edge.
   task automatic step(input logic c, input logic o, input logic w, input logic b,
                       input logic sup, input logic nva, input logic nvd,
                       input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic xen, input logic xev, input logic stores,
                       input string req);
      exp_t it;
      @(negedge clk);
      ce_n = c; oe_n = o; we_n = w; busy_n = b;
      supply_ok = sup; nv_active = nva; nv_done = nvd;
      addr = a; wdata = d;
      @(posedge clk);
      #1;
      it.en = xen; it.ev = xev; it.chk_d = xen; it.d = model[a]; it.req = req;
      sb.push_back(it);
      if (stores) model[a] = d;
   endtask

   task automatic idle(input string req);
      step(1, 1, 1, 1, 1, 0, 0, '0, '0, 0, 0, 0, req);
   endtask

   task automatic direct(input string req);
      checks++;
      if (dout_en !== 1'b0 || write_event !== 1'b0) begin
         fails++;
         $display("FAIL %s reset state en=%b ev=%b expected en=0 ev=0", req, dout_en, write_event);
      end
   endtask

   task automatic do_reset;
      @(negedge clk);
      #2;
      rst_n = 1'b0;
      #1;
      direct("R1");
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Monitor: pop and compare each expected item half a cycle after its edge.
   initial begin
      forever begin
         @(negedge clk);
         if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            checks++;
            if (dout_en !== it.en || write_event !== it.ev ||
                (it.chk_d && rdata !== it.d)) begin
               fails++;
               $display("FAIL %s en=%b/%b ev=%b/%b data=%h/%h (actual/expected)",
                        it.req, dout_en, it.en, write_event, it.ev, rdata, it.d);
            end
         end
      end
   end

   initial begin
      #(20 * 100000);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < (1 << AW); i++) model[i] = '0;
      #5;
      direct("R1");
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      idle("R1");

      // R3 and R6: write, hold, second write
      step(0, 1, 0, 1, 1, 0, 0, 10'd5, 8'hA5, 0, 1, 1, "R3");
      step(0, 1, 0, 1, 1, 0, 0, 10'd5, 8'hA5, 0, 0, 1, "R6");
      idle("R6");
      step(0, 1, 0, 1, 1, 0, 0, 10'd6, 8'h5A, 0, 1, 1, "R3");
      idle("R4");
      // R2: reads follow address
      step(0, 0, 1, 1, 1, 0, 0, 10'd5, 8'h00, 1, 0, 0, "R2");
      step(0, 0, 1, 1, 1, 0, 0, 10'd6, 8'h00, 1, 0, 0, "R2");
      // R4: deselect with oe low
      step(1, 0, 1, 1, 1, 0, 0, 10'd6, 8'h00, 0, 0, 0, "R4");
      // R5: write with oe low
      step(0, 0, 0, 1, 1, 0, 0, 10'd7, 8'h3C, 0, 1, 1, "R5");
      step(0, 0, 1, 1, 1, 0, 0, 10'd7, 8'h00, 1, 0, 0, "R5");
      step(1, 0, 0, 1, 1, 0, 0, 10'd9, 8'h77, 0, 0, 0, "R5");
      step(0, 0, 0, 1, 1, 0, 0, 10'd9, 8'h77, 0, 1, 1, "R5");
      idle("R5");
      step(0, 0, 1, 1, 1, 0, 0, 10'd9, 8'h00, 1, 0, 0, "R5");
      // R7: low supply
      step(0, 1, 0, 1, 0, 0, 0, 10'd5, 8'hEE, 0, 0, 0, "R7");
      idle("R7");
      step(0, 0, 1, 1, 1, 0, 0, 10'd5, 8'h00, 1, 0, 0, "R7");
      // R8: transfer active, busy low
      step(0, 1, 0, 1, 1, 1, 0, 10'd6, 8'hEE, 0, 0, 0, "R8");
      step(0, 0, 1, 1, 1, 1, 0, 10'd6, 8'h00, 0, 0, 0, "R8");
      idle("R8");
      step(0, 0, 1, 0, 1, 0, 0, 10'd6, 8'h00, 0, 0, 0, "R8");
      step(0, 1, 0, 0, 1, 0, 0, 10'd6, 8'hEE, 0, 0, 0, "R8");
      idle("R8");
      step(0, 0, 1, 1, 1, 0, 0, 10'd6, 8'h00, 1, 0, 0, "R8");
      // R9: completion under held write mode
      step(0, 1, 0, 1, 1, 0, 1, 10'd5, 8'h11, 0, 0, 0, "R9");
      step(0, 1, 0, 1, 1, 0, 0, 10'd5, 8'h22, 0, 0, 0, "R9");
      step(0, 1, 0, 1, 1, 0, 0, 10'd5, 8'h33, 0, 0, 0, "R9");
      step(0, 1, 1, 1, 1, 0, 0, 10'd5, 8'h00, 0, 0, 0, "R9");
      step(0, 1, 0, 1, 1, 0, 0, 10'd5, 8'h44, 0, 1, 1, "R9");
      idle("R9");
      step(0, 0, 1, 1, 1, 0, 0, 10'd5, 8'h00, 1, 0, 0, "R9");
      step(1, 1, 1, 1, 1, 0, 1, 10'd8, 8'h00, 0, 0, 0, "R9");
      step(0, 1, 0, 1, 1, 0, 0, 10'd8, 8'h66, 0, 1, 1, "R9");
      idle("R9");
      step(0, 0, 1, 1, 1, 0, 0, 10'd8, 8'h00, 1, 0, 0, "R9");
      // R10: reset released under write mode
      step(0, 1, 0, 1, 1, 0, 0, 10'd10, 8'h99, 0, 1, 1, "R3");
      wdata = 8'hAB;
      do_reset();
      step(0, 1, 0, 1, 1, 0, 0, 10'd10, 8'hAB, 0, 0, 0, "R10");
      step(0, 1, 0, 1, 1, 0, 0, 10'd10, 8'hAB, 0, 0, 0, "R10");
      idle("R10");
      step(0, 0, 1, 1, 1, 0, 0, 10'd10, 8'h00, 1, 0, 0, "R10");
      step(0, 1, 0, 1, 1, 0, 0, 10'd10, 8'hCD, 0, 1, 1, "R10");
      idle("R10");
      step(0, 0, 1, 1, 1, 0, 0, 10'd10, 8'h00, 1, 0, 0, "R10");
      idle("R4");
      repeat (3) @(negedge clk);
      #1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule